// File: doc/BRIEF.md
# Issue Slot Assigner for Four-Wide Instruction Packets

This block takes a packet of up to four decoded scalar instructions in each cycle and maps each one onto one of four issue slots. An upstream decoder supplies a small class code and a valid bit per lane. The block tells the issue stage whether the packet can issue as a whole, and which slot each instruction takes. A packet that does not fit is only flagged; it is never split into smaller packets.

Each class may use a fixed set of slots, and those sets are not the same size. Some classes may use only one slot, some may use a pair, and the general-purpose class may use any slot. Assignment therefore works through the lanes by how few slots they may use, so that the narrow classes claim their only slot before the flexible ones spread out. An end-of-loop marker takes no issue slot. It uses a separate loop resource, and a packet has only one of those.

The result is registered. It appears one clock after the packet is presented, together with a result-valid strobe.

Top module: `pkt_slot_assigner`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `res_valid`, `res_legal` and every field of `res_slot` to zero.
- R2: After each rising edge with `rst` low, `res_valid` equals the `pkt_valid` value sampled at that edge, and the result it marks belongs to the packet sampled at that same edge.
- R3: The class code is 3 bits, and lane i uses bits [3i+2:3i] of `lane_class`. The codes and the slots each may use are:
  - 0: any slot.
  - 1: slots 0 and 1.
  - 2: slot 0 only.
  - 3: slots 2 and 3.
  - 4: slots 2 and 3.
  - 5: slot 2 only.
  - 6: slot 3 only.
  - 7: end-of-loop marker, which uses no slot.
- R4: Lanes are placed in order of how many slots they may use, fewest first. Lanes that tie go in order of lowest lane index. Each lane takes the lowest-numbered slot that is still free and that its class permits. Lane i's slot index is reported in `res_slot[2i+1:2i]`.
- R5: If any valid lane that needs a slot finds no free slot its class permits, `res_legal` is 0 and every `res_slot` field is 0.
- R6: A valid end-of-loop lane takes no slot, and its `res_slot` field is 0. A packet with more than one valid end-of-loop lane is illegal.
- R7: A lane whose `lane_valid` bit is 0 has no effect on the assignment of the other lanes, and its `res_slot` field is 0.
- R8: A rising edge with `pkt_valid` low and `rst` low clears `res_valid` and leaves `res_legal` and `res_slot` unchanged.
- R9: When `res_valid` and `res_legal` are both 1, every valid slot-using lane has a slot its class permits, and no two such lanes share a slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_valid | input | 1 | A packet is presented this cycle |
| lane_valid | input | 4 | Per-lane valid bits |
| lane_class | input | 12 | Per-lane 3-bit class codes, lane 0 in the low bits |
| res_valid | output | 1 | Registered result is valid |
| res_legal | output | 1 | Packet fits the slots |
| res_slot | output | 8 | Per-lane 2-bit slot index, lane 0 in the low bits |

## Verification
The assertions take for granted that `rst`, `pkt_valid`, `lane_valid` and `lane_class` hold known values at every rising edge, and that `rst` is high at the first edge. Every 3-bit class value is defined, so the assertions assume nothing about which codes appear. The stimulus drives all inputs only at falling edges and always with known values. It starts in reset and takes reset again partway through the run. Directed packets cover the narrow-slot conflicts, the end-of-loop cases and lanes masked off by `lane_valid`. Random packets then mix every class code with random valid bits.

// File: rtl/pkt_slot_pkg.sv
package pkt_slot_pkg;

    localparam int LANES  = 4;
    localparam int SLOTS  = 4;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ANY    = 3'd0,
        CLS_MEM    = 3'd1,
        CLS_MEM0   = 3'd2,
        CLS_WIDE   = 3'd3,
        CLS_BRANCH = 3'd4,
        CLS_JREG   = 3'd5,
        CLS_CREG   = 3'd6,
        CLS_LOOP   = 3'd7
    } ins_class_e;

    typedef logic [SLOTS-1:0]  slot_mask_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;

    typedef struct packed {
        logic                        legal;
        slot_idx_t [LANES-1:0]       slot;
    } grant_t;

    // Slots a class may issue from; bit s set means slot s is permitted.
    function automatic slot_mask_t elig_mask(input ins_class_e c);
        case (c)
            CLS_ANY:    elig_mask = 4'b1111;
            CLS_MEM:    elig_mask = 4'b0011;
            CLS_MEM0:   elig_mask = 4'b0001;
            CLS_WIDE:   elig_mask = 4'b1100;
            CLS_BRANCH: elig_mask = 4'b1100;
            CLS_JREG:   elig_mask = 4'b0100;
            CLS_CREG:   elig_mask = 4'b1000;
            default:    elig_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/slot_class_decode.sv
module slot_class_decode
    import pkt_slot_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [N_LANES-1:0]             lane_valid,
    input  logic [N_LANES*CLS_W-1:0]       lane_class,
    output slot_mask_t [N_LANES-1:0]       req_mask,
    output logic [N_LANES-1:0]             loop_req
);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        ins_class_e cls;
        assign cls         = ins_class_e'(lane_class[g*CLS_W +: CLS_W]);
        assign req_mask[g] = lane_valid[g] ? elig_mask(cls) : '0;
        assign loop_req[g] = lane_valid[g] && (cls == CLS_LOOP);
    end

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
    import pkt_slot_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  slot_mask_t [N_LANES-1:0] req_mask,
    input  logic [N_LANES-1:0]       loop_req,
    output grant_t                   grant
);

    always_comb begin
        slot_mask_t                free;
        slot_idx_t [N_LANES-1:0]   pick;
        logic                      ok;
        logic                      got;
        free = '1;
        pick = '0;
        ok   = 1'b1;
        got  = 1'b0;
        // Narrowest lanes first; within one width, ascending lane index.
        for (int card = 1; card <= SLOTS; card++) begin
            for (int i = 0; i < N_LANES; i++) begin
                if (req_mask[i] != '0 && $countones(req_mask[i]) == card) begin
                    got = 1'b0;
                    for (int s = 0; s < SLOTS; s++) begin
                        if (!got && req_mask[i][s] && free[s]) begin
                            got     = 1'b1;
                            free[s] = 1'b0;
                            pick[i] = slot_idx_t'(s);
                        end
                    end
                    if (!got) ok = 1'b0;
                end
            end
        end
        if ($countones(loop_req) > 1) ok = 1'b0;
        grant.legal = ok;
        grant.slot  = ok ? pick : '0;
    end

endmodule

// File: rtl/pkt_slot_assigner.sv
module pkt_slot_assigner
    import pkt_slot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pkt_valid,
    input  logic [LANES-1:0]         lane_valid,
    input  logic [LANES*CLS_W-1:0]   lane_class,
    output logic                     res_valid,
    output logic                     res_legal,
    output logic [LANES*SLOT_W-1:0]  res_slot
);

    slot_mask_t [LANES-1:0] req_mask;
    logic [LANES-1:0]       loop_req;
    grant_t                 grant;
    grant_t                 held;

    slot_class_decode #(.N_LANES(LANES)) u_decode (
        .lane_valid (lane_valid),
        .lane_class (lane_class),
        .req_mask   (req_mask),
        .loop_req   (loop_req)
    );

    slot_alloc #(.N_LANES(LANES)) u_alloc (
        .req_mask (req_mask),
        .loop_req (loop_req),
        .grant    (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            held      <= '0;
        end else begin
            res_valid <= pkt_valid;
            if (pkt_valid) held <= grant;
        end
    end

    assign res_legal = held.legal;
    assign res_slot  = held.slot;

endmodule

// File: rtl/pkt_slot_chk.sv
module pkt_slot_chk
    import pkt_slot_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     pkt_valid,
    input logic [LANES-1:0]         lane_valid,
    input logic [LANES*CLS_W-1:0]   lane_class,
    input logic                     res_valid,
    input logic                     res_legal,
    input logic [LANES*SLOT_W-1:0]  res_slot
);

    logic [LANES-1:0]       cap_lv;
    logic [LANES*CLS_W-1:0] cap_cls;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lv  <= '0;
            cap_cls <= '0;
        end else if (pkt_valid) begin
            cap_lv  <= lane_valid;
            cap_cls <= lane_class;
        end
    end

    function automatic logic grant_sound(input logic [LANES-1:0] lv,
                                         input logic [LANES*CLS_W-1:0] cl,
                                         input logic [LANES*SLOT_W-1:0] sl);
        slot_mask_t used;
        slot_mask_t m;
        int         s;
        logic       okv;
        used = '0;
        okv  = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            m = elig_mask(ins_class_e'(cl[i*CLS_W +: CLS_W]));
            s = int'(sl[i*SLOT_W +: SLOT_W]);
            if (lv[i] && m != '0) begin
                if (!m[s] || used[s]) okv = 1'b0;
                used[s] = 1'b1;
            end
        end
        return okv;
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_legal && res_slot == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (res_valid == $past(pkt_valid)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> ($stable(res_legal) && $stable(res_slot)));

    // R5
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_legal) |-> (res_slot == '0));

    // R9
    grant_sound_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_legal) |-> grant_sound(cap_lv, cap_cls, res_slot));

endmodule

bind pkt_slot_assigner pkt_slot_chk u_chk (.*);

// File: tb/pkt_slot_assigner_bench.sv
`timescale 1ns/1ps
module pkt_slot_assigner_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [3:0]  lane_valid = '0;
    logic [11:0] lane_class = '0;
    logic        res_valid;
    logic        res_legal;
    logic [7:0]  res_slot;

    int checks = 0;
    int errors = 0;

    logic       e_valid = 1'b0;
    logic       e_legal = 1'b0;
    logic [7:0] e_slot  = '0;

    always #4 clk = ~clk;

    pkt_slot_assigner u_pkt_slot_assigner (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .lane_valid(lane_valid),
        .lane_class(lane_class), .res_valid(res_valid), .res_legal(res_legal),
        .res_slot(res_slot)
    );

    function automatic logic [11:0] pk(input int c0, input int c1, input int c2, input int c3);
        return {c3[2:0], c2[2:0], c1[2:0], c0[2:0]};
    endfunction

    // Permitted slots per class code, taken from the requirement list (R3).
    function automatic int allowed(input int c, input int s);
        case (c)
            0: return 1;
            1: return (s <= 1) ? 1 : 0;
            2: return (s == 0) ? 1 : 0;
            3, 4: return (s >= 2) ? 1 : 0;
            5: return (s == 2) ? 1 : 0;
            6: return (s == 3) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic model(input logic [3:0] lv, input logic [11:0] cl,
                         output logic lg, output logic [7:0] sl);
        int width[4];
        int taken[4];
        int res[4];
        int loops = 0;
        lg = 1'b1;
        for (int s = 0; s < 4; s++) taken[s] = 0;
        for (int i = 0; i < 4; i++) begin
            int c = int'(cl[i*3 +: 3]);
            res[i]   = 0;
            width[i] = 0;
            for (int s = 0; s < 4; s++) width[i] += allowed(c, s);
            if (lv[i] && c == 7) loops++;
        end
        for (int w = 1; w <= 4; w++) begin
            for (int i = 0; i < 4; i++) begin
                if (lv[i] && width[i] == w) begin
                    int c = int'(cl[i*3 +: 3]);
                    int found = -1;
                    for (int s = 3; s >= 0; s--)
                        if (taken[s] == 0 && allowed(c, s) == 1) found = s;
                    if (found < 0) lg = 1'b0;
                    else begin taken[found] = 1; res[i] = found; end
                end
            end
        end
        if (loops > 1) lg = 1'b0;
        sl = '0;
        if (lg) for (int i = 0; i < 4; i++) sl[i*2 +: 2] = 2'(res[i]);
    endtask

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic pv, input logic [3:0] lv,
                        input logic [11:0] cl, input string tag);
        logic lg;
        logic [7:0] sl;
        rst = r; pkt_valid = pv; lane_valid = lv; lane_class = cl;
        @(posedge clk);
        if (r) begin
            e_valid = 1'b0; e_legal = 1'b0; e_slot = '0;
        end else begin
            e_valid = pv;
            if (pv) begin
                model(lv, cl, lg, sl);
                e_legal = lg; e_slot = sl;
            end
        end
        @(negedge clk);
        check(res_valid === e_valid, tag, "res_valid", int'(res_valid), int'(e_valid));
        check(res_legal === e_legal, tag, "res_legal", int'(res_legal), int'(e_legal));
        check(res_slot === e_slot, tag, "res_slot", int'(res_slot), int'(e_slot));
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        // R1: reset state
        step(1, 1, 4'hF, pk(0, 0, 0, 0), "R1");
        step(1, 0, 4'h0, '0, "R1");
        // R4: four general lanes fill slots by index
        step(0, 1, 4'hF, pk(0, 0, 0, 0), "R4");
        check(res_slot === 8'b11_10_01_00, "R4", "any-order", int'(res_slot), 8'he4);
        // R4 R3: narrow lanes first
        step(0, 1, 4'hF, pk(0, 2, 5, 1), "R4");
        check(res_slot === 8'b01_10_00_11, "R4", "narrow-first", int'(res_slot), 8'h63);
        // R3: control-register lane to slot 3, wide to 2
        step(0, 1, 4'h3, pk(3, 6, 0, 0), "R3");
        check(res_slot === 8'b00_00_11_10, "R3", "creg-wide", int'(res_slot), 8'h0e);
        // R5: three lanes for two upper slots
        step(0, 1, 4'h7, pk(3, 4, 6, 0), "R5");
        check(res_legal === 1'b0, "R5", "upper-overflow", int'(res_legal), 0);
        step(0, 1, 4'h3, pk(2, 2, 0, 0), "R5");
        check(res_slot === 8'h00, "R5", "slot0-clash", int'(res_slot), 0);
        // R6: one loop marker with three general lanes
        step(0, 1, 4'hF, pk(0, 7, 0, 0), "R6");
        check(res_legal === 1'b1, "R6", "single-loop", int'(res_legal), 1);
        step(0, 1, 4'h5, pk(7, 0, 7, 0), "R6");
        check(res_legal === 1'b0, "R6", "double-loop", int'(res_legal), 0);
        // R7: masked lanes would clash but are ignored
        step(0, 1, 4'h5, pk(2, 2, 5, 5), "R7");
        check(res_legal === 1'b1 && res_slot === 8'h20, "R7", "masked", int'(res_slot), 8'h20);
        // R8: idle cycle holds previous result
        step(0, 0, 4'hF, pk(2, 2, 2, 2), "R8");
        check(res_slot === 8'h20 && res_legal === 1'b1, "R8", "hold", int'(res_slot), 8'h20);
        // R2 R9: random packets
        for (int n = 0; n < 400; n++) begin
            step(0, 1'($urandom_range(0, 3) != 0), 4'($urandom), 12'($urandom), "R2");
        end
        // R1: reset again mid-run
        step(1, 1, 4'hF, pk(0, 1, 3, 6), "R1");
        step(0, 1, 4'hF, pk(1, 1, 4, 4), "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule